// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It has two component predictors. The local component is a table of one-bit entries addressed by a slice of the fetch address. The global component is a second table of one-bit entries addressed by that same slice XORed with a register of recent branch outcomes. A third one-bit table, the chooser, is addressed exactly like the global table. Its entry decides which component supplies the final direction.

The fetch stage drives an address on the lookup port and reads, in the same cycle, the final direction and both component guesses. When the branch resolves, the execute stage presents the branch address, the real outcome and the two component guesses that were made for it. On that clock edge the block does four things. It overwrites both component entries with the outcome. It trains the chooser toward the component that was right, and only when the two guesses disagreed. It shifts the outcome into the history register. The table depth is 2^IDX_W entries. The full-size build sets IDX_W to 14, which gives 16K entries per table. The default is kept small so that elaboration stays light.

Top module: `tourn_predictor`

## Requirements
- R1: After reset every table entry and the history register read as zero. A lookup at any address then returns 0 on pred_local, pred_global and pred_taken, so the final direction comes from the local component and is not taken.
- R2: The local entry index is fetch address bits [LSB+IDX_W-1:LSB] (bits [15:5] by default). pred_local returns that entry. An update overwrites the entry for upd_addr with upd_taken.
- R3: The global entry index is the same address slice XORed with the history register, zero-extended to IDX_W bits. pred_global returns that entry. An update writes upd_taken to the global entry indexed with upd_addr and the history as it stands in the update cycle.
- R4: The chooser entry uses the global index. When it is 1, pred_taken equals pred_global. When it is 0, pred_taken equals pred_local.
- R5: The chooser entry is written only when upd_local differs from upd_global. It becomes 1 if upd_global equals upd_taken and 0 otherwise. When the two guesses agree, the chooser keeps its value.
- R6: Each cycle with upd_valid high shifts upd_taken into history bit 0 and drops the oldest bit. Without an update the history holds its value.
- R7: A lookup reflects the tables and history from before any update made in the same cycle. That update becomes visible on the following cycle.
- R8: Address bits outside the index slice have no effect. Two addresses that differ only in bits [4:0] or in bits above the slice share all three entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_addr | input | 32 | Fetch address for lookup |
| pred_taken | output | 1 | Final predicted direction (1 = taken) |
| pred_local | output | 1 | Local component guess |
| pred_global | output | 1 | Global component guess |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_addr | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_local | input | 1 | Local guess made for this branch |
| upd_global | input | 1 | Global guess made for this branch |

## Verification
A lookup and an update can fall in the same cycle, and they can land on the same local, global and chooser entries. The bench provokes this by driving an update and a lookup to one address together. It expects the lookup to return the old contents under the old history. On the next cycle it expects the freshly written values, now read under the shifted history. A pseudo-random phase restricts addresses to a few index values, so overlapping entries and history-dependent aliasing recur often. Every lookup is judged against a reference model that applies updates only after computing that cycle's expected outputs.

// File: rtl/tourn_pkg.sv
package tourn_pkg;

    // Chooser entry encoding: which component supplies the final direction
    typedef enum logic {
        SRC_LOCAL  = 1'b0,
        SRC_GLOBAL = 1'b1
    } src_e;

endpackage

// File: rtl/tourn_index.sv
module tourn_index #(
    parameter int IDX_W  = 11,
    parameter int HIST_W = 11
) (
    input  logic [IDX_W-1:0]  addr_slice,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  loc_idx,
    output logic [IDX_W-1:0]  glb_idx
);

    // local index: the address slice as-is
    assign loc_idx = addr_slice;

    // global index: history zero-extended into the low bits, then XOR
    assign glb_idx = addr_slice ^ IDX_W'(hist);

endmodule

// File: rtl/tourn_bit_table.sv
module tourn_bit_table #(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bit
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] mem;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_bit;
        end
    end

    // read is combinational: returns contents before this cycle's write
    assign rd_bit = mem[rd_idx];

    // R2 / R3: a write is present in the entry on the next cycle
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_idx)] == $past(wr_bit));

    // R5: without a write the whole table keeps its contents
    p_hold_without_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem));

endmodule

// File: rtl/tourn_predictor.sv
module tourn_predictor #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 11,
    parameter int HIST_W = 11,
    parameter int LSB    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pred_addr,
    output logic              pred_taken,
    output logic              pred_local,
    output logic              pred_global,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken,
    input  logic              upd_local,
    input  logic              upd_global
);
    import tourn_pkg::*;

    localparam int MSB = LSB + IDX_W - 1;

    logic [HIST_W-1:0] ghist;
    logic [IDX_W-1:0]  p_loc_idx, p_glb_idx;
    logic [IDX_W-1:0]  u_loc_idx, u_glb_idx;
    logic              chooser_bit;
    src_e              pick;
    logic              sel_wr_en;
    src_e              sel_wr_val;

    // bits outside the slice do not take part in indexing
    logic unused_addr_bits;
    assign unused_addr_bits = ^{pred_addr[ADDR_W-1:MSB+1], pred_addr[LSB-1:0],
                                upd_addr[ADDR_W-1:MSB+1],  upd_addr[LSB-1:0]};

    tourn_index #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_lookup_idx (
        .addr_slice (pred_addr[MSB:LSB]),
        .hist       (ghist),
        .loc_idx    (p_loc_idx),
        .glb_idx    (p_glb_idx)
    );

    tourn_index #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_train_idx (
        .addr_slice (upd_addr[MSB:LSB]),
        .hist       (ghist),
        .loc_idx    (u_loc_idx),
        .glb_idx    (u_glb_idx)
    );

    tourn_bit_table #(.IDX_W(IDX_W)) u_local_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (p_loc_idx),
        .rd_bit (pred_local),
        .wr_en  (upd_valid),
        .wr_idx (u_loc_idx),
        .wr_bit (upd_taken)
    );

    tourn_bit_table #(.IDX_W(IDX_W)) u_global_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (p_glb_idx),
        .rd_bit (pred_global),
        .wr_en  (upd_valid),
        .wr_idx (u_glb_idx),
        .wr_bit (upd_taken)
    );

    // chooser trains only on disagreement, toward the component that was right
    assign sel_wr_en  = upd_valid && (upd_local != upd_global);
    assign sel_wr_val = (upd_global == upd_taken) ? SRC_GLOBAL : SRC_LOCAL;

    tourn_bit_table #(.IDX_W(IDX_W)) u_chooser_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (p_glb_idx),
        .rd_bit (chooser_bit),
        .wr_en  (sel_wr_en),
        .wr_idx (u_glb_idx),
        .wr_bit (sel_wr_val)
    );

    assign pick = src_e'(chooser_bit);

    always_comb begin
        unique case (pick)
            SRC_GLOBAL: pred_taken = pred_global;
            SRC_LOCAL:  pred_taken = pred_local;
            default:    pred_taken = pred_local;
        endcase
    end

    // history register: newest outcome enters bit 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ghist <= '0;
        end else if (upd_valid) begin
            ghist <= {ghist[HIST_W-2:0], upd_taken};
        end
    end

    // R6: the resolved outcome is the newest history bit
    p_hist_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> ghist[0] == $past(upd_taken));

    // R6: older history moves up by one place
    p_hist_age_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> ghist[HIST_W-1:1] == $past(ghist[HIST_W-2:0]));

    // R6: no update, no history change
    p_hist_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(ghist));

    // R4: when the components agree the final direction matches both
    always_comb begin
        if (rst_n && (pred_local == pred_global)) begin
            p_agree_final_r4: assert (pred_taken == pred_local);
        end
    end

endmodule

// File: tb/tourn_predictor_bench.sv
module tourn_predictor_bench;

    localparam int IDX_W  = 11;
    localparam int HIST_W = 11;
    localparam int LSB    = 5;
    localparam int DEPTH  = 1 << IDX_W;

    typedef struct {
        logic  e_taken;
        logic  e_loc;
        logic  e_glb;
        string req;
    } item_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [31:0] pred_addr = '0;
    logic        pred_taken, pred_local, pred_global;
    logic        upd_valid = 0;
    logic [31:0] upd_addr = '0;
    logic        upd_taken = 0, upd_local = 0, upd_global = 0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    item_t q[$];

    // reference model
    bit              m_loc [DEPTH];
    bit              m_glb [DEPTH];
    bit              m_sel [DEPTH];
    bit [HIST_W-1:0] m_hist;

    always #10 clk = ~clk;   // 50 MHz

    tourn_predictor u_tourn_predictor (
        .clk         (clk),
        .rst_n       (rst_n),
        .pred_addr   (pred_addr),
        .pred_taken  (pred_taken),
        .pred_local  (pred_local),
        .pred_global (pred_global),
        .upd_valid   (upd_valid),
        .upd_addr    (upd_addr),
        .upd_taken   (upd_taken),
        .upd_local   (upd_local),
        .upd_global  (upd_global)
    );

    function automatic int lidx(input logic [31:0] a);
        return int'(a[LSB+IDX_W-1:LSB]);
    endfunction

    function automatic int gidx(input logic [31:0] a);
        logic [IDX_W-1:0] s;
        s = a[LSB+IDX_W-1:LSB] ^ IDX_W'(m_hist);
        return int'(s);
    endfunction

    // driver: one cycle of lookup plus optional update
    task automatic step(input logic [31:0] pa, input bit uv, input logic [31:0] ua,
                        input bit ut, input bit ul, input bit ug, input string req);
        item_t it;
        @(negedge clk);
        pred_addr  = pa;
        upd_valid  = uv;
        upd_addr   = ua;
        upd_taken  = ut;
        upd_local  = ul;
        upd_global = ug;
        it.e_loc   = m_loc[lidx(pa)];
        it.e_glb   = m_glb[gidx(pa)];
        it.e_taken = m_sel[gidx(pa)] ? it.e_glb : it.e_loc;
        it.req     = req;
        q.push_back(it);
        if (uv) begin
            m_loc[lidx(ua)] = ut;
            m_glb[gidx(ua)] = ut;
            if (ul != ug) m_sel[gidx(ua)] = (ug == ut);
            m_hist = {m_hist[HIST_W-2:0], ut};
        end
    endtask

    task automatic look(input logic [31:0] pa, input string req);
        step(pa, 0, '0, 0, 0, 0, req);
    endtask

    // monitor: compare in the low clock phase
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                total++;
                if (pred_local !== it.e_loc || pred_global !== it.e_glb ||
                    pred_taken !== it.e_taken) begin
                    bad++;
                    $display("FAIL %s: taken/local/global actual=%b%b%b expected=%b%b%b",
                             it.req, pred_taken, pred_local, pred_global,
                             it.e_taken, it.e_loc, it.e_glb);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b, rnd;
        for (int i = 0; i < DEPTH; i++) begin
            m_loc[i] = 0; m_glb[i] = 0; m_sel[i] = 0;
        end
        m_hist = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: everything reads zero after reset
        look(32'h0000_0000, "R1");
        look(32'h0000_1234, "R1");
        look(32'hFFFF_FFFF, "R1");
        look(32'h8000_FFE0, "R1");

        a = 32'h0000_0A40;
        // R2, R3: taken update with agreeing guesses, then read back
        step(a, 1, a, 1, 0, 0, "R7 same-cycle lookup sees old state");
        look(a, "R2 local entry written");
        look(a ^ 32'h20, "R3 global entry under new history");

        // R6: history walks; no-update cycles keep it
        step(32'h0, 1, 32'h0, 0, 0, 0, "R6");
        step(32'h0, 1, 32'h0, 1, 0, 0, "R6");
        look(32'h0000_0040, "R6 history after shifts");
        look(32'h0000_0040, "R6 history held without update");

        // R5: agreement leaves chooser; disagreement trains it
        b = 32'h0000_3300;
        step(b, 1, b, 1, 1, 1, "R5 agree");
        look(b, "R5 chooser unchanged on agreement");
        step(b, 1, b, 1, 0, 1, "R5 global right");
        step(b, 1, b, 0, 0, 1, "R5 local right");
        step(b, 1, b, 1, 1, 0, "R5 local right again");

        // R4: build a case where local and global differ and chooser selects global
        m_hist = m_hist;
        for (int k = 0; k < 12; k++) begin
            step(b, 1, b, k[0], ~k[0], k[0], "R4 chooser training");
            look(b, "R4 final pick");
            look(b ^ 32'h0000_0100, "R4 neighbour");
        end

        // R7: same-cycle update and lookup to one address, then next cycle
        step(b, 1, b, 0, 1, 0, "R7 lookup during update");
        look(b, "R7 update visible next cycle");

        // R8: aliasing through bits outside the slice
        a = 32'h0000_5560;
        step(a, 1, a, 1, 0, 1, "R8");
        look(a | 32'h0000_001F, "R8 low bits ignored");
        look(a | 32'hABCD_0000, "R8 high bits ignored");

        // mixed phase: few index values so entries collide often
        rnd = 32'h1357_9BDF;
        for (int n = 0; n < 600; n++) begin
            logic [31:0] pa, ua;
            bit ul, ug;
            rnd = rnd ^ (rnd << 13);
            rnd = rnd ^ (rnd >> 17);
            rnd = rnd ^ (rnd << 5);
            pa = {rnd[31:24], 13'h0, rnd[2:0], rnd[12:8]};
            ua = {rnd[23:16], 13'h0, rnd[5:3], rnd[17:13]};
            if (rnd[20]) begin
                ul = m_loc[lidx(ua)];
                ug = m_glb[gidx(ua)];
            end else begin
                ul = rnd[21];
                ug = rnd[22];
            end
            step(pa, rnd[25] | rnd[26], ua, rnd[27], ul, ug, "R2,R3,R4,R5,R6 mixed");
        end

        // reset again: R1
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < DEPTH; i++) begin
            m_loc[i] = 0; m_glb[i] = 0; m_sel[i] = 0;
        end
        m_hist = '0;
        look(b, "R1 after second reset");
        look(a, "R1 after second reset");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule